// File: doc/BRIEF.md
# Bus Target Selection Monitor

This block sits beside the control and data lines of a parallel peripheral bus and tells a target device when a host has selected it. All bus inputs are treated as active-high (the pad logic has already inverted the bus's low-true levels). They pass through a two-flop synchronizer before any decision is made. When select is seen with busy inactive, the block scans the data byte against a small table of target IDs. On a hit it latches a status word and drives busy. After a settle window it samples the attention line to tell whether the host can send messages. If attention is inactive, it marks the host as a legacy host.

A separate path filters bus-reset glitches. The reset line is sampled when it is first seen active and again a fixed time later, and a sticky flag is raised only when both samples are active. Software clears the flag through a dedicated input. A bus-free request returns the selection side to idle and releases busy. Timing windows are written in nanoseconds and converted to clock cycles from the clock frequency parameter.

There is no data stream in this block, so there is no valid/ready pair and no back-pressure. Every input and output is a plain level-sensitive control or status pin.

Top module: `selmon_top`

## Requirements
- R1: After reset, `bsy_o`, `selected_o`, `legacy_o`, `atn_host_o`, `bus_rst_o` are 0 and `sel_status_o` is 8'h00.
- R2: A selection is taken when the synchronized select input is 1 and the synchronized busy input is 0, even if busy is never asserted. The status, `selected_o` and `bsy_o` update on the third rising clock edge after the inputs change.
- R3: No selection is taken while `bsy_i`, `bsy_held_i` or the block's own `bsy_o` is 1.
- R4: The table entries (entry i in `ids_i[i*IDW +: IDW]`, enabled by `en_i[i]`) are tried from index 0 upward. The first entry that is enabled, has an ID of 7 or less, and whose data bit `data_i[ID]` is 1 wins. An entry with an ID above 7 never matches.
- R5: On a hit, `sel_status_o` becomes {bit7 = 1 (selection succeeded), bit6 = 1 (attention, set without looking), bits 5:3 = 0, bits 2:0 = ID}. Without a hit the status stays 8'h00 and `bsy_o` stays 0.
- R6: `selected_o` is latched at detection and stays 1 after select is released, until a bus-free request.
- R7: ATN_CYC cycles after `bsy_o` rises, the synchronized attention input is sampled. If it is 0, status bit 6 is cleared, `legacy_o` is set and `atn_host_o` stays 0. If it is 1, `atn_host_o` is set and `legacy_o` stays 0.
- R8: A `bus_free_i` pulse clears the status, `selected_o`, `legacy_o`, `atn_host_o` and `bsy_o` at the next edge. While `bus_free_i` is high, a pending selection is held off.
- R9: `bus_rst_o` is set only if the synchronized reset input is 1 at its rising transition and again RST_CYC cycles later. A shorter pulse leaves it 0.
- R10: `bus_rst_o` stays 1 until `rst_clr_i`. A set in the same cycle as a clear wins. A clear while the reset line stays active leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Bus select line, active-high |
| bsy_i | input | 1 | Bus busy line, active-high |
| atn_i | input | 1 | Bus attention line, active-high |
| rst_bus_i | input | 1 | Bus reset line, active-high |
| data_i | input | 8 | Bus data byte |
| ids_i | input | NT*IDW | Target ID table, entry i at bits i*IDW upward |
| en_i | input | NT | Per-entry enable |
| bsy_held_i | input | 1 | Device is driving busy through another path |
| bus_free_i | input | 1 | Request to return to bus free |
| rst_clr_i | input | 1 | Clear for the bus-reset flag |
| bsy_o | output | 1 | Drive busy onto the bus |
| sel_status_o | output | 8 | Selection status word |
| selected_o | output | 1 | Latched selected indication |
| atn_host_o | output | 1 | Host kept attention asserted after busy |
| legacy_o | output | 1 | Legacy-host compatibility mode |
| bus_rst_o | output | 1 | Filtered, sticky bus-reset flag |

## Verification
A bus-free request and a fresh selection can arrive in the same cycle. The bench provokes this by holding `bus_free_i` high while a matching select is already present on the synchronized inputs. It then checks that no status is latched and that the selection is taken on the edge right after the request drops. The reset filter's set and the software clear can also coincide. The bench times `rst_clr_i` to the exact edge of the second reset sample and expects the flag to read 1.

// File: rtl/selmon_pkg.sv
package selmon_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_HOLD} sel_state_e;

  localparam int unsigned STAT_OK_BIT  = 7;
  localparam int unsigned STAT_ATN_BIT = 6;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/selmon_sync.sv
module selmon_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/selmon_match.sv
module selmon_match #(
  parameter int NT  = 4,
  parameter int IDW = 4
) (
  input  logic [7:0]      data_i,
  input  logic [NT*IDW-1:0] ids_i,
  input  logic [NT-1:0]   en_i,
  output logic            hit_o,
  output logic [2:0]      id_o
);
  logic [NT-1:0] cand;
  logic [2:0]    low_id [NT];

  for (genvar g = 0; g < NT; g++) begin : g_ent
    logic [IDW-1:0] ent;
    assign ent       = ids_i[g*IDW +: IDW];
    assign low_id[g] = ent[2:0];
    assign cand[g]   = en_i[g] && (ent <= IDW'(7)) && data_i[ent[2:0]];
  end

  always_comb begin
    hit_o = 1'b0;
    id_o  = 3'd0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o = 1'b1;
        id_o  = low_id[i];
      end
    end
  end
endmodule

// File: rtl/selmon_rst_filter.sv
module selmon_rst_filter #(
  parameter int GAP = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int CW = $clog2(GAP + 1);

  logic          prev_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          confirm;

  assign confirm = busy_q && (cnt_q == '0) && line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (!busy_q && line_i && !prev_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(GAP - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (confirm)    flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/selmon_select.sv
module selmon_select
  import selmon_pkg::*;
#(
  parameter int ATN_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_s,
  input  logic       bsy_s,
  input  logic       atn_s,
  input  logic       hit_i,
  input  logic [2:0] hit_id_i,
  input  logic       bsy_held_i,
  input  logic       bus_free_i,
  output logic       bsy_o,
  output logic [7:0] status_o,
  output logic       selected_o,
  output logic       atn_host_o,
  output logic       legacy_o
);
  localparam int ACW = $clog2(ATN_CYC + 1);

  sel_state_e     state_q;
  logic [ACW-1:0] wait_q;
  logic           take;

  assign take = !bsy_held_i && !bsy_o && sel_s && !bsy_s && hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wait_q     <= '0;
      bsy_o      <= 1'b0;
      status_o   <= 8'h00;
      selected_o <= 1'b0;
      atn_host_o <= 1'b0;
      legacy_o   <= 1'b0;
    end else if (bus_free_i) begin
      state_q    <= ST_IDLE;
      bsy_o      <= 1'b0;
      status_o   <= 8'h00;
      selected_o <= 1'b0;
      atn_host_o <= 1'b0;
      legacy_o   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          status_o   <= {1'b1, 1'b1, 3'b000, hit_id_i};
          selected_o <= 1'b1;
          bsy_o      <= 1'b1;
          atn_host_o <= 1'b0;
          legacy_o   <= 1'b0;
          wait_q     <= ACW'(ATN_CYC - 1);
          state_q    <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (wait_q == '0) begin
            if (atn_s) begin
              atn_host_o <= 1'b1;
            end else begin
              status_o[STAT_ATN_BIT] <= 1'b0;
              legacy_o               <= 1'b1;
            end
            state_q <= ST_HOLD;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/selmon_top.sv
module selmon_top
  import selmon_pkg::*;
#(
  parameter int NT      = 4,
  parameter int IDW     = 4,
  parameter int CLK_MHZ = 50,
  parameter int ATN_NS  = 100,
  parameter int RST_NS  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              bsy_i,
  input  logic              atn_i,
  input  logic              rst_bus_i,
  input  logic [7:0]        data_i,
  input  logic [NT*IDW-1:0] ids_i,
  input  logic [NT-1:0]     en_i,
  input  logic              bsy_held_i,
  input  logic              bus_free_i,
  input  logic              rst_clr_i,
  output logic              bsy_o,
  output logic [7:0]        sel_status_o,
  output logic              selected_o,
  output logic              atn_host_o,
  output logic              legacy_o,
  output logic              bus_rst_o
);
  localparam int ATN_CYC = int'(ns_to_cyc(ATN_NS, CLK_MHZ));
  localparam int RST_CYC = int'(ns_to_cyc(RST_NS, CLK_MHZ));
  localparam int SW      = 12;

  logic [SW-1:0] raw, synced;
  logic          hit;
  logic [2:0]    hit_id;

  assign raw = {rst_bus_i, atn_i, bsy_i, sel_i, data_i};

  selmon_sync #(.W(SW)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  selmon_match #(.NT(NT), .IDW(IDW)) i_match (
    .data_i(synced[7:0]), .ids_i(ids_i), .en_i(en_i),
    .hit_o(hit), .id_o(hit_id)
  );

  selmon_select #(.ATN_CYC(ATN_CYC)) i_select (
    .clk(clk), .rst_n(rst_n),
    .sel_s(synced[8]), .bsy_s(synced[9]), .atn_s(synced[10]),
    .hit_i(hit), .hit_id_i(hit_id),
    .bsy_held_i(bsy_held_i), .bus_free_i(bus_free_i),
    .bsy_o(bsy_o), .status_o(sel_status_o), .selected_o(selected_o),
    .atn_host_o(atn_host_o), .legacy_o(legacy_o)
  );

  selmon_rst_filter #(.GAP(RST_CYC)) i_rstf (
    .clk(clk), .rst_n(rst_n), .line_i(synced[11]),
    .clr_i(rst_clr_i), .flag_o(bus_rst_o)
  );
endmodule

// File: rtl/selmon_checks.sv
module selmon_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       bsy_held_i,
  input logic       bus_free_i,
  input logic       rst_clr_i,
  input logic       bsy_o,
  input logic [7:0] sel_status_o,
  input logic       selected_o,
  input logic       atn_host_o,
  input logic       legacy_o,
  input logic       bus_rst_o
);
  p_no_take_when_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> !$past(bsy_held_i));

  p_status_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_o |-> (sel_status_o[7] && sel_status_o[5:3] == 3'b000));

  p_id_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_status_o[7] && !bus_free_i) |=> $stable(sel_status_o[2:0]));

  p_selected_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selected_o && !bus_free_i) |=> selected_o);

  p_legacy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_o |-> (!sel_status_o[6] && !atn_host_o));

  p_bus_free_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_i |=> (sel_status_o == 8'h00 && !bsy_o && !selected_o && !legacy_o && !atn_host_o));

  p_flag_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rst_o) |-> $past(rst_clr_i));
endmodule

bind selmon_top selmon_checks i_checks (
  .clk(clk), .rst_n(rst_n), .bsy_held_i(bsy_held_i), .bus_free_i(bus_free_i),
  .rst_clr_i(rst_clr_i), .bsy_o(bsy_o), .sel_status_o(sel_status_o),
  .selected_o(selected_o), .atn_host_o(atn_host_o), .legacy_o(legacy_o),
  .bus_rst_o(bus_rst_o)
);

// File: tb/test_selmon_top.sv
module test_selmon_top;
  localparam int CLK_PERIOD = 20;
  localparam int NT = 4;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 0, bsy_i = 0, atn_i = 0, rst_bus_i = 0;
  logic [7:0] data_i = 8'h00;
  logic [NT*IDW-1:0] ids_i = '0;
  logic [NT-1:0] en_i = '0;
  logic bsy_held_i = 0, bus_free_i = 0, rst_clr_i = 0;
  logic bsy_o, selected_o, atn_host_o, legacy_o, bus_rst_o;
  logic [7:0] sel_status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selmon_top #(.NT(NT), .IDW(IDW), .CLK_MHZ(50), .ATN_NS(100), .RST_NS(500)) i_selmon_top (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i), .atn_i(atn_i),
    .rst_bus_i(rst_bus_i), .data_i(data_i), .ids_i(ids_i), .en_i(en_i),
    .bsy_held_i(bsy_held_i), .bus_free_i(bus_free_i), .rst_clr_i(rst_clr_i),
    .bsy_o(bsy_o), .sel_status_o(sel_status_o), .selected_o(selected_o),
    .atn_host_o(atn_host_o), .legacy_o(legacy_o), .bus_rst_o(bus_rst_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_hit(logic [NT*IDW-1:0] ids, logic [NT-1:0] en, logic [7:0] d);
    logic [3:0] r = 4'h0;
    for (int i = 0; i < NT; i++) begin
      logic [IDW-1:0] e = ids[i*IDW +: IDW];
      if (!r[3] && en[i] && e < 8 && d[e[2:0]]) r = {1'b1, e[2:0]};
    end
    return r;
  endfunction

  function automatic logic [11:0] outs();
    return {bsy_o, selected_o, legacy_o, atn_host_o, sel_status_o};
  endfunction

  task automatic release_and_free();
    sel_i = 0;
    tick(4);
    bus_free_i = 1;
    tick(1);
    bus_free_i = 0;
  endtask

  task automatic trial(logic [7:0] d, bit a);
    logic [3:0]  h;
    logic [11:0] exp;
    h = exp_hit(ids_i, en_i, d);
    exp = h[3] ? {1'b1, 1'b1, !a, a, 1'b1, a, 3'b000, h[2:0]} : 12'h000;
    data_i = d; atn_i = a; sel_i = 1; bsy_i = 0;
    tick(12);
    check(outs() == exp, "R4_R5_R7", "sweep outputs", int'(outs()), int'(exp));
    sel_i = 0;
    tick(4);
    check(selected_o == h[3], "R6", "selected after SEL release", selected_o, h[3]);
    bus_free_i = 1;
    tick(1);
    bus_free_i = 0;
    check(outs() == 12'h000, "R8", "after bus free", int'(outs()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(outs() == 12'h000 && !bus_rst_o, "R1", "reset state", int'(outs()), 0);
    rst_n = 1;
    tick(2);
    check(outs() == 12'h000 && !bus_rst_o, "R1", "after reset release", int'(outs()), 0);

    // table A: idx0=5, idx1=2, idx2=9 (out of range), idx3=0
    ids_i = {4'd0, 4'd9, 4'd2, 4'd5}; en_i = 4'b1111;
    for (int d = 0; d < 256; d++) trial(8'(d), ^8'(d));
    // table B: only idx1 (id 3) and idx3 (id 1) enabled
    ids_i = {4'd1, 4'd7, 4'd3, 4'd3}; en_i = 4'b1010;
    for (int d = 0; d < 256; d++) trial(8'(d), ~^8'(d));

    // R2 timing: SEL alone, busy never asserted; visible on third edge
    ids_i = {4'd0, 4'd9, 4'd2, 4'd5}; en_i = 4'b1111;
    data_i = 8'h20; atn_i = 1; sel_i = 1;
    tick(2);
    check(!selected_o, "R2", "not yet after two edges", selected_o, 0);
    tick(1);
    check(selected_o && bsy_o && sel_status_o == 8'hC5, "R2", "selected on third edge",
          int'(sel_status_o), 8'hC5);
    release_and_free();

    // R3: busy line active blocks selection
    bsy_i = 1; sel_i = 1;
    tick(12);
    check(outs() == 12'h000, "R3", "bus busy blocks", int'(outs()), 0);
    bsy_i = 0; sel_i = 0;
    tick(4);
    // R3: device holding busy blocks selection
    bsy_held_i = 1; sel_i = 1;
    tick(12);
    check(outs() == 12'h000, "R3", "held busy blocks", int'(outs()), 0);
    sel_i = 0;
    tick(4);
    bsy_held_i = 0;

    // R8: bus free and selection collide
    bus_free_i = 1; sel_i = 1; data_i = 8'h04;
    tick(8);
    check(sel_status_o == 8'h00 && !bsy_o, "R8", "held off by bus free", int'(sel_status_o), 0);
    bus_free_i = 0;
    tick(1);
    check(selected_o && sel_status_o == 8'hC2, "R8", "taken right after bus free drops",
          int'(sel_status_o), 8'hC2);
    release_and_free();

    // R9: short pulse rejected
    rst_bus_i = 1;
    tick(3);
    rst_bus_i = 0;
    tick(40);
    check(!bus_rst_o, "R9", "glitch rejected", bus_rst_o, 0);
    // R9: long pulse accepted
    rst_bus_i = 1;
    tick(35);
    check(bus_rst_o, "R9", "long reset accepted", bus_rst_o, 1);
    // R10: clear while line active stays clear
    rst_clr_i = 1;
    tick(1);
    rst_clr_i = 0;
    check(!bus_rst_o, "R10", "cleared", bus_rst_o, 0);
    tick(10);
    check(!bus_rst_o, "R10", "no re-set while line held", bus_rst_o, 0);
    check(bus_rst_o == 0, "R10", "sticky-clear holds", bus_rst_o, 0);
    rst_bus_i = 0;
    tick(40);
    // R10: set and clear in the same cycle, set wins
    rst_bus_i = 1;
    tick(27);
    rst_clr_i = 1;
    tick(1);
    rst_clr_i = 0;
    check(bus_rst_o, "R10", "set beats clear", bus_rst_o, 1);
    tick(5);
    check(bus_rst_o, "R10", "flag sticky", bus_rst_o, 1);
    rst_bus_i = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule